// File: doc/BRIEF.md
# CAN Message-Object Register Bank

This block holds the message objects of a CAN controller on the processor side of the chip. Each object is a 16-byte slot. It contains two control bytes of flags, four identifier bytes, a configuration byte, eight payload bytes and one spare byte. A byte-wide processor bus reads and writes any slot by address. A second port belongs to the controller core. The core uses it to flag arrivals, overruns and remote requests, to retire transmit requests and to raise per-object interrupts.

Every flag in the control bytes is written through its own two-bit field. One code clears the flag, another sets it, and the other codes leave it alone. Software can therefore change one flag without a read-modify-write. All enabled and pending interrupts are combined into one interrupt line. Slot 0 sits in the address space of the global registers and is not an object.

Top module: `mob_bank`

## Requirements
- R1: Object n (1 to 15) occupies addresses n*16 to n*16+15. The slot offsets are: 0 control byte A, 1 control byte B, 2 to 5 identifier bytes 0 to 3, 6 configuration, 7 to 14 payload bytes 0 to 7. Bytes written to offsets 2 to 14 read back unchanged.
- R2: A read of a control byte returns, for each flag, the pair 10 when the flag is set and 01 when it is clear. Control byte A holds, from bits 1:0 upward: interrupt pending, receive interrupt enable, transmit interrupt enable, object valid. Control byte B holds, from bits 1:0 upward: new data, message lost, transmit request, remote request pending.
- R3: In a control-byte write, field code 01 clears the flag and 10 sets it. Codes 11 and 00 leave the flag unchanged.
- R4: Slot 0 and offset 15 of every slot always read as zero, and writes to them have no effect.
- R5: The core port names an object by `core_obj`. It can set interrupt pending, new data, message lost and remote pending, and it can clear transmit request. No other object is affected.
- R6: When a processor write and a core action touch the same flag in the same cycle, the core action decides the result.
- R7: When the core sets new data on an object whose new-data flag is already set, message lost is set as well.
- R8: `irq` is high while any object has object valid and interrupt pending set, together with its transmit interrupt enable if configuration bit 3 (transmit direction) is 1, or its receive interrupt enable if that bit is 0. Configuration bit 2 marks an extended identifier and is stored like the other configuration bits.
- R9: After reset every flag and every stored byte is zero, so control bytes read 0x55 and `irq` is low.
- R10: With the default `REG_RD`=1, `cpu_rdata` shows the byte addressed by `cpu_addr` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | Byte address: slot in the upper bits, offset in the low 4 bits |
| cpu_we | input | 1 | Write strobe for `cpu_wdata` at `cpu_addr` |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` |
| core_obj | input | ADDR_W-4 | Object addressed by the core strobes |
| core_set_intpnd | input | 1 | Core sets interrupt pending |
| core_set_newdat | input | 1 | Core sets new data |
| core_set_msglst | input | 1 | Core sets message lost |
| core_set_rmtpnd | input | 1 | Core sets remote request pending |
| core_clr_txrqst | input | 1 | Core clears transmit request |
| irq | output | 1 | Combined interrupt request |

## Verification
A write or a core strobe takes effect on the next rising edge. Read data for an address is registered on the edge after the address is driven. The interrupt line follows the flag registers with no extra delay, so it is correct in the same cycle as the updated flags. The bench drives inputs on falling edges. Its monitor compares each read one full cycle after the address went out, popping the expected byte that the driver queued. Interrupt checks sample on the falling edge right after the edge that applied the stimulus.

// File: rtl/mob_pkg.sv
package mob_pkg;
   localparam int NFLAGS   = 8;
   localparam int FLD_W    = 2;
   localparam int BYTE_W   = 8;

   // flag positions, control byte A then control byte B, low pair first
   localparam int FL_INTPND = 0;
   localparam int FL_RXIE   = 1;
   localparam int FL_TXIE   = 2;
   localparam int FL_VALID  = 3;
   localparam int FL_NEWDAT = 4;
   localparam int FL_MSGLST = 5;
   localparam int FL_TXRQST = 6;
   localparam int FL_RMTPND = 7;

   localparam logic [FLD_W-1:0] CODE_CLR = 2'b01;
   localparam logic [FLD_W-1:0] CODE_SET = 2'b10;

   localparam int CFG_EXT_BIT = 2;
   localparam int CFG_DIR_BIT = 3;

   // read encoding of four flags into one control byte
   function automatic logic [BYTE_W-1:0] enc_ctl(input logic [3:0] f);
      logic [BYTE_W-1:0] r;
      for (int i = 0; i < 4; i++) r[2*i +: 2] = f[i] ? CODE_SET : CODE_CLR;
      return r;
   endfunction
endpackage

// File: rtl/mob_flag.sv
module mob_flag
   import mob_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [FLD_W-1:0] wr_code,
   input  logic             core_set,
   input  logic             core_clr,
   output logic             q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= 1'b0;
      else if (core_set)                        q <= 1'b1;
      else if (core_clr)                        q <= 1'b0;
      else if (wr_en && wr_code == CODE_SET)    q <= 1'b1;
      else if (wr_en && wr_code == CODE_CLR)    q <= 1'b0;
   end

   // R6: core action overrides any processor code
   p_core_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      core_set |=> q);
   p_core_clr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (core_clr && !core_set) |=> !q);
   // R3: keep codes and idle cycles hold the flag
   p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_set && !core_clr &&
       !(wr_en && (wr_code == CODE_SET || wr_code == CODE_CLR))) |=> $stable(q));
endmodule

// File: rtl/mob_slot.sv
module mob_slot
   import mob_pkg::*;
#(
   parameter int OFF_W      = 4,
   parameter int ID_BYTES   = 4,
   parameter int DATA_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [BYTE_W-1:0] rd_data,
   input  logic [NFLAGS-1:0] core_set,
   input  logic [NFLAGS-1:0] core_clr,
   output logic              irq_req
);
   localparam int ID_BASE   = 2;
   localparam int CFG_OFF   = ID_BASE + ID_BYTES;
   localparam int DATA_BASE = CFG_OFF + 1;
   localparam int USED      = DATA_BASE + DATA_BYTES;

   if (USED > 2**OFF_W) begin : g_bad_layout
      $error("mob_slot: %0d bytes do not fit a %0d-byte slot", USED, 2**OFF_W);
   end

   logic [BYTE_W-1:0] id_q   [ID_BYTES];
   logic [BYTE_W-1:0] data_q [DATA_BYTES];
   logic [BYTE_W-1:0] cfg_q;
   logic [NFLAGS-1:0] flag_q;
   logic [NFLAGS-1:0] set_eff;

   // R7: a second arrival on a full object marks an overrun
   always_comb begin
      set_eff = core_set;
      set_eff[FL_MSGLST] = core_set[FL_MSGLST] | (core_set[FL_NEWDAT] & flag_q[FL_NEWDAT]);
   end

   for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
      localparam int CTL_OFF = g / 4;
      localparam int FPOS    = (g % 4) * FLD_W;
      mob_flag u_flag (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_en && wr_off == OFF_W'(CTL_OFF)),
         .wr_code  (wr_data[FPOS +: FLD_W]),
         .core_set (set_eff[g]),
         .core_clr (core_clr[g]),
         .q        (flag_q[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         for (int k = 0; k < ID_BYTES; k++)   id_q[k]   <= '0;
         for (int k = 0; k < DATA_BYTES; k++) data_q[k] <= '0;
      end else if (wr_en) begin
         if (wr_off == OFF_W'(CFG_OFF)) cfg_q <= wr_data;
         for (int k = 0; k < ID_BYTES; k++)
            if (wr_off == OFF_W'(ID_BASE + k)) id_q[k] <= wr_data;
         for (int k = 0; k < DATA_BYTES; k++)
            if (wr_off == OFF_W'(DATA_BASE + k)) data_q[k] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_off == OFF_W'(0)) rd_data = enc_ctl(flag_q[3:0]);
      if (rd_off == OFF_W'(1)) rd_data = enc_ctl(flag_q[7:4]);
      if (rd_off == OFF_W'(CFG_OFF)) rd_data = cfg_q;
      for (int k = 0; k < ID_BYTES; k++)
         if (rd_off == OFF_W'(ID_BASE + k)) rd_data = id_q[k];
      for (int k = 0; k < DATA_BYTES; k++)
         if (rd_off == OFF_W'(DATA_BASE + k)) rd_data = data_q[k];
   end

   assign irq_req = flag_q[FL_VALID] & flag_q[FL_INTPND] &
                    (cfg_q[CFG_DIR_BIT] ? flag_q[FL_TXIE] : flag_q[FL_RXIE]);

   p_overrun_sets_lost_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (core_set[FL_NEWDAT] && flag_q[FL_NEWDAT]) |=> flag_q[FL_MSGLST]);
endmodule

// File: rtl/mob_rdmux.sv
module mob_rdmux
   import mob_pkg::*;
#(
   parameter bit REG_RD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] d,
   output logic [BYTE_W-1:0] q
);
   if (REG_RD) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign q = d;
   end
endmodule

// File: rtl/mob_bank.sv
module mob_bank
   import mob_pkg::*;
#(
   parameter int NUM_OBJ    = 15,
   parameter int ADDR_W     = 8,
   parameter int ID_BYTES   = 4,
   parameter int DATA_BYTES = 8,
   parameter bit REG_RD     = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   cpu_addr,
   input  logic                cpu_we,
   input  logic [7:0]          cpu_wdata,
   output logic [7:0]          cpu_rdata,
   input  logic [ADDR_W-5:0]   core_obj,
   input  logic                core_set_intpnd,
   input  logic                core_set_newdat,
   input  logic                core_set_msglst,
   input  logic                core_set_rmtpnd,
   input  logic                core_clr_txrqst,
   output logic                irq
);
   localparam int OFF_W     = 4;
   localparam int SLOT_W    = ADDR_W - OFF_W;
   localparam int NUM_SLOTS = 2**SLOT_W;

   if (SLOT_W < 1) begin : g_bad_addr
      $error("mob_bank: ADDR_W %0d too small", ADDR_W);
   end
   if (NUM_OBJ < 1 || NUM_OBJ > NUM_SLOTS - 1) begin : g_bad_count
      $error("mob_bank: NUM_OBJ %0d outside 1..%0d", NUM_OBJ, NUM_SLOTS - 1);
   end

   logic [SLOT_W-1:0] slot_sel;
   logic [OFF_W-1:0]  off_sel;
   assign slot_sel = cpu_addr[ADDR_W-1:OFF_W];
   assign off_sel  = cpu_addr[OFF_W-1:0];

   logic [NFLAGS-1:0] set_req, clr_req;
   always_comb begin
      set_req = '0;
      clr_req = '0;
      set_req[FL_INTPND] = core_set_intpnd;
      set_req[FL_NEWDAT] = core_set_newdat;
      set_req[FL_MSGLST] = core_set_msglst;
      set_req[FL_RMTPND] = core_set_rmtpnd;
      clr_req[FL_TXRQST] = core_clr_txrqst;
   end

   logic [7:0]       rd_vec [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] req_vec;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      if (s >= 1 && s <= NUM_OBJ) begin : g_obj
         logic hit_core;
         assign hit_core = (core_obj == SLOT_W'(s));
         mob_slot #(
            .OFF_W      (OFF_W),
            .ID_BYTES   (ID_BYTES),
            .DATA_BYTES (DATA_BYTES)
         ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cpu_we && slot_sel == SLOT_W'(s)),
            .wr_off   (off_sel),
            .wr_data  (cpu_wdata),
            .rd_off   (off_sel),
            .rd_data  (rd_vec[s]),
            .core_set (hit_core ? set_req : '0),
            .core_clr (hit_core ? clr_req : '0),
            .irq_req  (req_vec[s])
         );
      end else begin : g_empty
         assign rd_vec[s]  = '0;
         assign req_vec[s] = 1'b0;
      end
   end

   mob_rdmux #(.REG_RD(REG_RD)) u_rdmux (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rd_vec[slot_sel]),
      .q     (cpu_rdata)
   );

   assign irq = |req_vec;

   if (REG_RD) begin : g_chk_rd
      p_global_slot_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (slot_sel == '0) |=> (cpu_rdata == 8'h00));
      p_spare_byte_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (off_sel == '1) |=> (cpu_rdata == 8'h00));
   end
endmodule

// File: tb/sim_mob_bank.sv
module sim_mob_bank;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic [7:0] cpu_addr = '0;
   logic       cpu_we = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic [3:0] core_obj = '0;
   logic       c_int = 0, c_new = 0, c_lst = 0, c_rmt = 0, c_ctx = 0;
   logic       irq;

   mob_bank u0 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .core_obj(core_obj),
      .core_set_intpnd(c_int), .core_set_newdat(c_new), .core_set_msglst(c_lst),
      .core_set_rmtpnd(c_rmt), .core_clr_txrqst(c_ctx), .irq(irq)
   );

   int vectors = 0;
   int miscomp = 0;
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic rd_act = 1'b0, rd_act_d = 1'b0;

   // monitor: one cycle of read latency (R10)
   always @(posedge clk) rd_act_d <= rd_act;
   always @(negedge clk) begin
      if (rd_act_d && exp_q.size() > 0) begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         vectors++;
         if (cpu_rdata !== e) begin
            miscomp++;
            $display("FAIL %s: rdata=%02h expected %02h", t, cpu_rdata, e);
         end
      end
   end

   task automatic clr_in();
      cpu_we = 0; rd_act = 0;
      c_int = 0; c_new = 0; c_lst = 0; c_rmt = 0; c_ctx = 0;
   endtask

   // cs = {clr_txrqst, set_rmtpnd, set_msglst, set_newdat, set_intpnd}
   task automatic step(input logic we, input logic [3:0] obj, input logic [3:0] off,
                       input logic [7:0] d, input logic [3:0] cobj, input logic [4:0] cs);
      @(negedge clk);
      clr_in();
      cpu_we = we; cpu_addr = {obj, off}; cpu_wdata = d;
      core_obj = cobj;
      {c_ctx, c_rmt, c_lst, c_new, c_int} = cs;
   endtask

   task automatic wr(input logic [3:0] obj, input logic [3:0] off, input logic [7:0] d);
      step(1'b1, obj, off, d, 4'd0, 5'b0);
   endtask

   task automatic core(input logic [3:0] cobj, input logic [4:0] cs);
      step(1'b0, 4'd0, 4'd0, 8'h00, cobj, cs);
   endtask

   task automatic rd(input logic [3:0] obj, input logic [3:0] off,
                     input logic [7:0] e, input string t);
      @(negedge clk);
      clr_in();
      cpu_addr = {obj, off};
      rd_act = 1;
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic chk_irq(input logic e, input string t);
      @(negedge clk);
      clr_in();
      vectors++;
      if (irq !== e) begin
         miscomp++;
         $display("FAIL %s: irq=%0b expected %0b", t, irq, e);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      miscomp++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      rd(4'd1, 4'd0, 8'h55, "R9 ctrlA after reset");
      rd(4'd1, 4'd1, 8'h55, "R9 ctrlB after reset");
      rd(4'd15, 4'd9, 8'h00, "R9 payload after reset");
      chk_irq(1'b0, "R9 irq after reset");

      // R1 slot layout round trip
      for (int k = 2; k < 15; k++) wr(4'd3, 4'(k), 8'(8'h30 + k));
      wr(4'd3, 4'd6, 8'h04);   // configuration: extended id, receive direction
      for (int k = 2; k < 15; k++)
         rd(4'd3, 4'(k), (k == 6) ? 8'h04 : 8'(8'h30 + k), "R1 slot byte readback");
      rd(4'd4, 4'd7, 8'h00, "R1 neighbour slot untouched");

      // R4 spare byte and slot 0
      wr(4'd3, 4'd15, 8'hA5);
      rd(4'd3, 4'd15, 8'h00, "R4 spare byte reads zero");
      wr(4'd0, 4'd7, 8'h77);
      rd(4'd0, 4'd7, 8'h00, "R4 slot 0 reads zero");

      // R2 R3 control byte A codes
      wr(4'd3, 4'd0, 8'h99);
      rd(4'd3, 4'd0, 8'h99, "R2 ctrlA set/clear encoding");
      wr(4'd3, 4'd0, 8'hFF);
      rd(4'd3, 4'd0, 8'h99, "R3 code 11 keeps");
      wr(4'd3, 4'd0, 8'h00);
      rd(4'd3, 4'd0, 8'h99, "R3 code 00 keeps");
      wr(4'd3, 4'd0, 8'h7F);
      rd(4'd3, 4'd0, 8'h59, "R3 clear valid only");

      // R8 interrupt combining
      core(4'd3, 5'b00001);
      chk_irq(1'b0, "R8 invalid object masks irq");
      wr(4'd3, 4'd0, 8'hBF);
      chk_irq(1'b1, "R8 valid receive object irq");
      wr(4'd3, 4'd6, 8'h08);
      chk_irq(1'b0, "R8 transmit object needs txie");
      wr(4'd3, 4'd0, 8'hEF);
      chk_irq(1'b1, "R8 transmit object with txie");
      wr(4'd3, 4'd0, 8'hFD);
      chk_irq(1'b0, "R8 pending cleared");

      // R5 R7 core port
      core(4'd5, 5'b00010);
      rd(4'd5, 4'd1, 8'h56, "R5 core sets new data");
      core(4'd5, 5'b00010);
      rd(4'd5, 4'd1, 8'h5A, "R7 overrun sets message lost");
      core(4'd5, 5'b01000);
      rd(4'd5, 4'd1, 8'h9A, "R5 core sets remote pending");
      wr(4'd5, 4'd1, 8'hEF);
      rd(4'd5, 4'd1, 8'hAA, "R3 processor sets tx request");
      core(4'd5, 5'b10000);
      rd(4'd5, 4'd1, 8'h9A, "R5 core clears tx request");
      rd(4'd6, 4'd1, 8'h55, "R5 other object untouched");

      // R6 same-cycle conflicts
      step(1'b1, 4'd5, 4'd1, 8'h55, 4'd5, 5'b00010);
      rd(4'd5, 4'd1, 8'h5A, "R6 core set beats processor clear");
      step(1'b1, 4'd5, 4'd1, 8'hEF, 4'd5, 5'b10000);
      rd(4'd5, 4'd1, 8'h5A, "R6 core clear beats processor set");

      repeat (3) begin
         @(negedge clk);
         clr_in();
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
   end
endmodule